// File: doc/BRIEF.md
# Service Request Status Byte

This block builds the 8-bit status byte of an instrument bus interface and drives its service-request line. It watches four sources: a flag that says the reply queue holds at least one message, a flag that says the error queue holds at least one message, a latched standard event register together with its enable mask, and a ready-summary input. A host loads a service-request enable mask and can read the status byte at any time. A serial-poll strobe reads the byte a second way and clears the pending request.

Bit 6 depends on the path used to read it. On the query path it is a live summary: it is high while any enabled cause is present. On the poll path it is a latched request flag. That flag sets when the summary rises and clears when a poll happens. The service-request line follows the latched flag.

Top module: `svc_req_status`

## Requirements
- R1: Bits 7, 3 and 1 of both `queryByte` and `pollByte` always read 0.
- R2: Bit 4 equals `outQueueBusy` and bit 2 equals `errQueueBusy` in both bytes, with no delay.
- R3: Bit 5 is 1 when `stdEvent & stdEventEn` is nonzero and 0 otherwise.
- R4: Bit 0 equals `readySummary`.
- R5: A cycle with `enWrite` high loads `enData` into the enable mask on that clock edge. Bit 6 of the written value is dropped, so it has no effect on any output.
- R6: `queryByte` bit 6 is 1 exactly when any of status bits 0, 2, 4 or 5 is also set in the enable mask. It uses the mask value as it is after the last write.
- R7: When the summary of R6 goes from 0 to 1 at a clock edge, the request flag is set after that edge. `srqLine` and `pollByte` bit 6 both show this flag.
- R8: A cycle with `pollStrobe` high clears the request flag at that edge. The flag does not set again while the summary stays high. It needs a new 0-to-1 transition of the summary.
- R9: After reset the enable mask is 0, the request flag is 0 and `srqLine` is low.
- R10: If a summary rise and a poll fall on the same edge, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| outQueueBusy | input | 1 | Reply queue holds at least one message |
| errQueueBusy | input | 1 | Error queue holds at least one message |
| stdEvent | input | 8 | Latched standard event register |
| stdEventEn | input | 8 | Enable mask for the standard event register |
| readySummary | input | 1 | Summary of the enabled ready events |
| enWrite | input | 1 | Loads the service-request enable mask |
| enData | input | 8 | Value for the enable mask |
| pollStrobe | input | 1 | Serial poll; clears the request flag |
| queryByte | output | 8 | Status byte, bit 6 = live summary |
| pollByte | output | 8 | Status byte, bit 6 = latched request |
| srqLine | output | 1 | Service-request line |

## Verification
The checks that run on every cycle cover the following:
- the request flag only rises after a cycle in which the summary was high;
- a set strobe always leaves the flag set;
- a poll without a concurrent rise always leaves it clear;
- bit 6 of the stored mask is never 1 after a write.

The bench scenarios show the rest:
- the bit layout of both bytes;
- the masking by values such as 0x14;
- the need for a fresh summary edge after a poll;
- the race of a poll against a new rise;
- the live summary dropping while the latched request stays high.

// File: rtl/svc_pkg.sv
package svc_pkg;
  localparam int BIT_RSR = 0;
  localparam int BIT_ERR = 2;
  localparam int BIT_MAV = 4;
  localparam int BIT_ESB = 5;
  localparam int BIT_RQS = 6;

  typedef struct packed {
    logic loadEnable;
    logic clearRqs;
    logic setRqs;
  } ctlStrobes_t;
endpackage

// File: rtl/svc_ctl.sv
module svc_ctl
  import svc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enWrite,
  input  logic        pollStrobe,
  input  logic        summary,
  output ctlStrobes_t ctl
);
  logic prevSummary;

  always_ff @(posedge clk) begin
    if (!rst_n) prevSummary <= 1'b0;
    else        prevSummary <= summary;
  end

  always_comb begin
    ctl.loadEnable = enWrite;
    ctl.setRqs     = summary & ~prevSummary;
    ctl.clearRqs   = pollStrobe;
  end
endmodule

// File: rtl/svc_dp.sv
module svc_dp
  import svc_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int EVT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctlStrobes_t         ctl,
  input  logic                outQueueBusy,
  input  logic                errQueueBusy,
  input  logic [EVT_W-1:0]    stdEvent,
  input  logic [EVT_W-1:0]    stdEventEn,
  input  logic                readySummary,
  input  logic [STATUS_W-1:0] enData,
  output logic                summary,
  output logic [STATUS_W-1:0] queryByte,
  output logic [STATUS_W-1:0] pollByte,
  output logic                rqsOut
);
  localparam logic [STATUS_W-1:0] RQS_MASK = STATUS_W'(1) << BIT_RQS;

  logic [STATUS_W-1:0] sreReg;
  logic [STATUS_W-1:0] causeBits;
  logic                rqsReg;

  always_comb begin
    causeBits          = '0;
    causeBits[BIT_RSR] = readySummary;
    causeBits[BIT_ERR] = errQueueBusy;
    causeBits[BIT_MAV] = outQueueBusy;
    causeBits[BIT_ESB] = |(stdEvent & stdEventEn);
  end

  assign summary = |(causeBits & sreReg & ~RQS_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreReg <= '0;
      rqsReg <= 1'b0;
    end else begin
      if (ctl.loadEnable) sreReg <= enData & ~RQS_MASK;
      if (ctl.setRqs)        rqsReg <= 1'b1;
      else if (ctl.clearRqs) rqsReg <= 1'b0;
    end
  end

  always_comb begin
    queryByte          = causeBits;
    queryByte[BIT_RQS] = summary;
    pollByte           = causeBits;
    pollByte[BIT_RQS]  = rqsReg;
  end

  assign rqsOut = rqsReg;

  // R7: a set strobe always leaves the flag set
  p_set_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.setRqs |=> rqsReg);
  // R7: the flag only rises after a cycle with an active summary
  p_rise_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rqsReg) |-> $past(summary));
  // R8: a poll with no concurrent rise leaves the flag clear
  p_poll_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clearRqs && !ctl.setRqs) |=> !rqsReg);
  // R5: bit 6 of the mask never sticks
  p_mask_bit6_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadEnable |=> !sreReg[BIT_RQS]);
endmodule

// File: rtl/svc_req_status.sv
module svc_req_status
  import svc_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int EVT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                outQueueBusy,
  input  logic                errQueueBusy,
  input  logic [EVT_W-1:0]    stdEvent,
  input  logic [EVT_W-1:0]    stdEventEn,
  input  logic                readySummary,
  input  logic                enWrite,
  input  logic [STATUS_W-1:0] enData,
  input  logic                pollStrobe,
  output logic [STATUS_W-1:0] queryByte,
  output logic [STATUS_W-1:0] pollByte,
  output logic                srqLine
);
  ctlStrobes_t ctl;
  logic        summary;
  logic        rqsOut;

  svc_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .enWrite(enWrite),
    .pollStrobe(pollStrobe), .summary(summary), .ctl(ctl)
  );

  svc_dp #(.STATUS_W(STATUS_W), .EVT_W(EVT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .outQueueBusy(outQueueBusy), .errQueueBusy(errQueueBusy),
    .stdEvent(stdEvent), .stdEventEn(stdEventEn),
    .readySummary(readySummary), .enData(enData),
    .summary(summary), .queryByte(queryByte), .pollByte(pollByte),
    .rqsOut(rqsOut)
  );

  assign srqLine = rqsOut;
endmodule

// File: tb/sim_svc_req_status.sv
module sim_svc_req_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic outQueueBusy = 0, errQueueBusy = 0, readySummary = 0;
  logic [7:0] stdEvent = 0, stdEventEn = 0;
  logic enWrite = 0, pollStrobe = 0;
  logic [7:0] enData = 0;
  logic [7:0] queryByte, pollByte;
  logic srqLine;

  always #4 clk = ~clk;

  svc_req_status u0 (.*);

  typedef struct {
    logic [7:0] q;
    logic [7:0] p;
    logic       s;
    string      tag;
  } item_t;

  item_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] mSre = 0;
  logic       mRqs = 0;
  logic       mPrev = 0;

  function automatic logic [7:0] causes(logic mav, logic err, logic [7:0] ev,
                                        logic [7:0] een, logic rdy);
    logic [7:0] c;
    c = 8'h00;
    c[0] = rdy; c[2] = err; c[4] = mav; c[5] = |(ev & een);
    return c;
  endfunction

  task automatic step(input logic mav, input logic err, input logic [7:0] ev,
                      input logic [7:0] een, input logic rdy, input logic wr,
                      input logic [7:0] wd, input logic poll, input string tag);
    logic [7:0] c;
    logic sumOld, sumNew;
    item_t it;
    @(negedge clk);
    outQueueBusy = mav; errQueueBusy = err; stdEvent = ev; stdEventEn = een;
    readySummary = rdy; enWrite = wr; enData = wd; pollStrobe = poll;
    c = causes(mav, err, ev, een, rdy);
    sumOld = |(c & mSre & 8'hBF);
    if (sumOld && !mPrev) mRqs = 1'b1;
    else if (poll)        mRqs = 1'b0;
    mPrev = sumOld;
    if (wr) mSre = wd & 8'hBF;
    sumNew = |(c & mSre & 8'hBF);
    it.q = c | {1'b0, sumNew, 6'b0};
    it.p = c | {1'b0, mRqs, 6'b0};
    it.s = mRqs;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        item_t e;
        e = expQ.pop_front();
        total++;
        if (queryByte !== e.q || pollByte !== e.p || srqLine !== e.s) begin
          bad++;
          $display("FAIL %s: got q=%02h p=%02h srq=%b exp q=%02h p=%02h srq=%b",
                   e.tag, queryByte, pollByte, srqLine, e.q, e.p, e.s);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    total++;
    if (queryByte !== 8'h00 || pollByte !== 8'h00 || srqLine !== 1'b0) begin
      bad++;
      $display("FAIL R9: got q=%02h p=%02h srq=%b exp q=00 p=00 srq=0",
               queryByte, pollByte, srqLine);
    end
    step(1, 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, "R2 mav bit4 mask zero");
    step(1, 0, 8'h00, 8'h00, 0, 1, 8'h54, 0, "R5 R6 write 0x54 bit6 dropped");
    step(1, 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, "R7 rqs set on rise");
    step(1, 0, 8'h00, 8'h00, 0, 0, 8'h00, 1, "R8 poll clears");
    step(1, 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, "R8 no reset without edge");
    step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, "R6 summary low");
    step(0, 1, 8'h00, 8'h00, 0, 0, 8'h00, 0, "R2 error bit2");
    step(0, 1, 8'h00, 8'h00, 0, 0, 8'h00, 0, "R7 rqs set by error");
    step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, "R7 rqs held mss low");
    step(0, 1, 8'h00, 8'h00, 0, 0, 8'h00, 1, "R10 rise with poll");
    step(0, 1, 8'h00, 8'h00, 0, 0, 8'h00, 1, "R10 R8 poll after");
    step(0, 0, 8'h80, 8'h01, 0, 1, 8'h20, 0, "R3 esb masked off");
    step(0, 0, 8'h81, 8'h01, 0, 0, 8'h00, 0, "R3 esb set");
    step(0, 0, 8'h81, 8'h01, 0, 0, 8'h00, 1, "R3 esb poll");
    step(0, 0, 8'h00, 8'h00, 1, 0, 8'h00, 0, "R4 rsr bit0 not enabled");
    step(1, 1, 8'hFF, 8'hFF, 1, 1, 8'hFF, 0, "R1 unused bits zero");
    step(1, 1, 8'hFF, 8'hFF, 1, 0, 8'h00, 0, "R1 R6 all causes");
    step(0, 0, 8'h00, 8'h00, 0, 1, 8'h40, 0, "R5 only bit6 written");
    step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, 1, "R8 final poll");
    step(1, 1, 8'hFF, 8'hFF, 1, 0, 8'h00, 0, "R5 bit6 mask no effect");
    step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, 0, "R1 idle");
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule